// File: doc/BRIEF.md
# Bidirectional Gate-Line Scan Shifter

This block walks a single select token across the row (gate) lines of an active-matrix display, one row per rising clock edge. A start pulse captured on a clock edge enters either at the first row or at the last row, as the direction input selects. From there the token moves one position per edge toward the far end, where it falls off without wrapping. The next frame begins only when a new start pulse arrives. All outputs are logic-level, and the bit index of `rows_o` equals the row number minus one.

Three controls shape what leaves the block. The output enable blanks every row without clearing the shift state. The double-scan mode keeps each row high for two clock periods, so the newly selected row and the one selected a clock earlier are high together. The asynchronous early-cut input, valid only in double-scan mode, drops the older row of that pair from its own rising edge until the next rising clock edge.

Top module: `gate_scan_top`

## Requirements
- R1: While reset is applied, and after it is released with no start pulse, every row output is low, whatever the start and mode inputs do. The internal mode flag is also clear.
- R2: With `scan_up` = 1, a start value of 1 sampled on a rising edge makes `rows_o[0]` high after that edge. The token then advances from bit i to bit i+1 on each later edge.
- R3: With `scan_up` = 0, a start value of 1 sampled on a rising edge makes `rows_o[N_ROWS-1]` high after that edge. The token then moves from bit i to bit i-1 on each later edge.
- R4: A token shifted past the last bit in its direction is discarded. It never re-enters at the other end, and all rows stay low until a new start pulse arrives.
- R5: When `out_en` is 0, every row output is low. The token keeps advancing underneath, so with `out_en` back at 1 the row shown is the token's current position.
- R6: A `dbl_in` value of 1 sampled on a rising edge makes the rows after that edge show the current token row together with the row the token held one edge earlier.
- R7: In double-scan mode every row the token passes stays high for two consecutive clock periods.
- R8: In double-scan mode, a rising edge on `cut_in` drives the older row of the pair low at once, while the newer row stays high. The older row stays low until the next rising clock edge, after which the normal pair display returns.
- R9: When the sampled double-scan flag is 0, `cut_in` has no effect on any row output.
- R10: A change of `dbl_in` between clock edges leaves the row outputs unchanged until the next rising edge samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_up | input | 1 | 1: token enters at bit 0 and moves upward; 0: enters at the top bit and moves downward |
| start_in | input | 1 | Start pulse, sampled on the rising clock edge |
| dbl_in | input | 1 | Double-scan request, sampled on the rising clock edge |
| out_en | input | 1 | 1: rows driven from the shift state; 0: all rows forced low |
| cut_in | input | 1 | Asynchronous early-cut; its rising edge blanks the older row of a double-scan pair until the next clock edge |
| rows_o | output | N_ROWS | Row select outputs, bit k drives row k+1 |

## Verification
The hardest situation to reach is the early-cut window. It exists only between a rising edge on `cut_in` and the next clock edge, and only while a double-scan pair is on the rows. The stimulus raises `cut_in` half a clock period after an edge in the middle of a double-scan run. It samples the rows inside that window, then lets the next edge close it. The same mid-cycle probe is repeated in single mode and during a mode change, which covers R9 and R10. A token is also pushed off each end of the register to show that it is dropped and not wrapped.

// File: rtl/gs_pkg.sv
package gs_pkg;

  // Scan direction as seen by the shift core.
  typedef enum logic {
    SCAN_DOWN = 1'b0,
    SCAN_UP   = 1'b1
  } scan_dir_e;

endpackage

// File: rtl/gs_reset_sync.sv
module gs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_n_o = pipe_q[LAST];

endmodule

// File: rtl/gs_shift_core.sv
module gs_shift_core
  import gs_pkg::*;
#(
  parameter int N_ROWS = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scan_dir_e         dir_i,
  input  logic              start_i,
  input  logic              dbl_i,
  output logic [N_ROWS-1:0] sel_o,
  output logic [N_ROWS-1:0] trail_o,
  output logic              dbl_o
);

  localparam int TOP = N_ROWS - 1;

  logic [N_ROWS-1:0] sel_q, sel_d;
  logic [N_ROWS-1:0] trail_q, trail_d;
  logic              dbl_q, dbl_d;
  logic              adv_en;

  // The shift chain advances on every edge out of reset.
  assign adv_en = 1'b1;

  always_comb begin
    sel_d   = sel_q;
    trail_d = trail_q;
    dbl_d   = dbl_i;
    if (adv_en) begin
      trail_d = sel_q;
      if (dir_i == SCAN_UP) begin
        sel_d = {sel_q[TOP-1:0], start_i};
      end else begin
        sel_d = {start_i, sel_q[TOP:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      trail_q <= '0;
      dbl_q   <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      trail_q <= trail_d;
      dbl_q   <= dbl_d;
    end
  end

  assign sel_o   = sel_q;
  assign trail_o = trail_q;
  assign dbl_o   = dbl_q;

  // R2: upward entry at bit 0 and single-step movement
  assert_enter_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_i == SCAN_UP) |=> (sel_q[0] == $past(start_i)) &&
                           (sel_q[TOP:1] == $past(sel_q[TOP-1:0])));

  // R3: downward entry at the top bit and single-step movement
  assert_enter_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_i == SCAN_DOWN) |=> (sel_q[TOP] == $past(start_i)) &&
                             (sel_q[TOP-1:0] == $past(sel_q[TOP:1])));

  // R4: a token leaving the top never reappears at the bottom
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_i == SCAN_UP && sel_q[TOP] && !start_i) |=> !sel_q[0]);

endmodule

// File: rtl/gs_cut_catch.sv
module gs_cut_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic arst_n,
  input  logic cut_i,
  output logic pend_o
);

  // A toggle in the cut domain and an echo in the clock domain:
  // they differ from a cut rising edge until the next clock edge.
  logic tog_q, tog_d;
  logic echo_q, echo_d;

  always_comb begin
    tog_d  = ~tog_q;
    echo_d = tog_q;
  end

  always_ff @(posedge cut_i or negedge arst_n) begin
    if (!arst_n) begin
      tog_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_q <= 1'b0;
    end else begin
      echo_q <= echo_d;
    end
  end

  assign pend_o = tog_q ^ echo_q;

endmodule

// File: rtl/gs_row_gate.sv
module gs_row_gate #(
  parameter int N_ROWS = 240
) (
  input  logic              en_i,
  input  logic              dbl_i,
  input  logic              pend_i,
  input  logic [N_ROWS-1:0] sel_i,
  input  logic [N_ROWS-1:0] trail_i,
  output logic [N_ROWS-1:0] rows_o
);

  logic keep_ext;

  assign keep_ext = dbl_i & ~pend_i;

  for (genvar g = 0; g < N_ROWS; g++) begin : g_row
    assign rows_o[g] = en_i & (sel_i[g] | (keep_ext & trail_i[g]));
  end

endmodule

// File: rtl/gate_scan_top.sv
module gate_scan_top
  import gs_pkg::*;
#(
  parameter int N_ROWS     = 240,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_up,
  input  logic              start_in,
  input  logic              dbl_in,
  input  logic              out_en,
  input  logic              cut_in,
  output logic [N_ROWS-1:0] rows_o
);

  logic              rst_sync_n;
  logic [N_ROWS-1:0] sel_vec;
  logic [N_ROWS-1:0] trail_vec;
  logic              dbl_q;
  logic              cut_pend;

  gs_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  gs_shift_core #(.N_ROWS(N_ROWS)) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dir_i   (scan_dir_e'(scan_up)),
    .start_i (start_in),
    .dbl_i   (dbl_in),
    .sel_o   (sel_vec),
    .trail_o (trail_vec),
    .dbl_o   (dbl_q)
  );

  gs_cut_catch u_cut (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .arst_n (rst_n),
    .cut_i  (cut_in),
    .pend_o (cut_pend)
  );

  gs_row_gate #(.N_ROWS(N_ROWS)) u_gate (
    .en_i    (out_en),
    .dbl_i   (dbl_q),
    .pend_i  (cut_pend),
    .sel_i   (sel_vec),
    .trail_i (trail_vec),
    .rows_o  (rows_o)
  );

  // R1: no row is ever high while the synchronized reset holds
  always @(posedge clk) begin
    if (!rst_sync_n) begin
      assert_reset_quiet_R1: assert (rows_o == '0);
    end
  end

  // R7: in double-scan mode, rows selected one edge ago are still high
  assert_pair_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dbl_q && out_en && !cut_pend) |->
      ((rows_o & $past(sel_vec)) == $past(sel_vec)));

endmodule

// File: tb/tb_gate_scan_top.sv
`timescale 1ns/100ps
module tb_gate_scan_top;

  localparam int N = 240;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         scan_up, start_in, dbl_in, out_en, cut_in;
  logic [N-1:0] rows_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  // Requirement-level reference state
  logic [N-1:0] m_sel, m_tr;
  logic         m_dbl, m_en;

  gate_scan_top #(.N_ROWS(N)) dut (
    .clk(clk), .rst_n(rst_n), .scan_up(scan_up), .start_in(start_in),
    .dbl_in(dbl_in), .out_en(out_en), .cut_in(cut_in), .rows_o(rows_o)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rows actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare one queued expectation shortly after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        check(rows_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  function automatic logic [N-1:0] shown(input logic cut);
    if (!m_en) return '0;
    return m_sel | ((m_dbl && !cut) ? m_tr : '0);
  endfunction

  // probe: 0 none, 1 early-cut inside the cycle, 2 mode change inside the cycle
  task automatic step(input logic st, input logic db, input logic en,
                      input logic up, input int probe, input string tag);
    logic [N-1:0] nxt;
    @(negedge clk);
    if (probe == 1) begin
      cut_in = 1'b1;
      #0.5;
      check(rows_o, shown(1'b1), {tag, " mid-cycle cut"});
      cut_in = 1'b0;
    end
    start_in = st; dbl_in = db; out_en = en; scan_up = up;
    if (probe == 2) begin
      #0.5;
      check(rows_o, m_en ? (m_sel | (m_dbl ? m_tr : '0)) & {N{1'b1}} : '0,
            {tag, " mode held until edge"});
    end
    nxt = up ? {m_sel[N-2:0], st} : {st, m_sel[N-1:1]};
    m_tr  = m_sel;
    m_sel = nxt;
    m_dbl = db;
    m_en  = en;
    // blanking is evaluated on the live enable
    exp_q.push_back(shown(1'b0));
    tag_q.push_back(tag);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; start_in = 1'b1; dbl_in = 1'b1; out_en = 1'b1;
    #0.5;
    check(rows_o, '0, "R1 immediate clear");
    repeat (3) @(negedge clk);
    check(rows_o, '0, "R1 held in reset with start high");
    start_in = 1'b0; dbl_in = 1'b0;
    rst_n = 1'b1;
    m_sel = '0; m_tr = '0; m_dbl = 1'b0; m_en = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 0, "R1 after release");
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; scan_up = 1'b1; start_in = 1'b0; dbl_in = 1'b0;
    out_en = 1'b1; cut_in = 1'b0;
    m_sel = '0; m_tr = '0; m_dbl = 1'b0; m_en = 1'b1;
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    apply_reset();

    // R2 and R4: upward scan run past the top end
    step(1'b1, 1'b0, 1'b1, 1'b1, 0, "R2 entry at row 1");
    for (int k = 1; k < N + 3; k++)
      step(1'b0, 1'b0, 1'b1, 1'b1, 0, (k < N) ? "R2 upward shift" : "R4 dropped at top");

    // R3 and R4: downward scan run past the bottom end
    step(1'b1, 1'b0, 1'b1, 1'b0, 0, "R3 entry at last row");
    for (int k = 1; k < N + 3; k++)
      step(1'b0, 1'b0, 1'b1, 1'b0, 0, (k < N) ? "R3 downward shift" : "R4 dropped at bottom");

    // R5: blank for a while, token keeps moving
    step(1'b1, 1'b0, 1'b1, 1'b1, 0, "R5 start");
    for (int k = 0; k < 4; k++)  step(1'b0, 1'b0, 1'b1, 1'b1, 0, "R5 enabled");
    for (int k = 0; k < 6; k++)  step(1'b0, 1'b0, 1'b0, 1'b1, 0, "R5 blanked");
    for (int k = 0; k < 4; k++)  step(1'b0, 1'b0, 1'b1, 1'b1, 0, "R5 resumed position");
    for (int k = 0; k < 8; k++)  step(1'b0, 1'b0, 1'b1, 1'b1, 0, "R5 flush");

    // R9: early-cut in single mode leaves rows alone
    step(1'b1, 1'b0, 1'b1, 1'b0, 0, "R9 start");
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b1, 1'b0, 1, "R9 cut ignored");

    // R10: mode request inside a cycle, then R6/R7 double scan upward
    apply_reset();
    step(1'b0, 1'b0, 1'b1, 1'b1, 2, "R10 mode request");
    step(1'b1, 1'b1, 1'b1, 1'b1, 0, "R6 pair start");
    for (int k = 1; k < N + 3; k++) begin
      if (k % 37 == 5)
        step(1'b0, 1'b1, 1'b1, 1'b1, 1, "R8 early cut");
      else
        step(1'b0, 1'b1, 1'b1, 1'b1, 0, (k < N) ? "R7 pair advance" : "R4 pair tail");
    end

    // R10: leaving double mode mid-run, then R8 on a downward pair
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R6 down pair start");
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b1, 1'b0, 1, "R8 cut on down pair");
    step(1'b0, 1'b0, 1'b1, 1'b0, 2, "R10 mode release");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b1, 1'b0, 0, "R10 single again");

    // R1: reset in the middle of a run
    apply_reset();
    for (int k = 0; k < 2; k++) step(1'b0, 1'b0, 1'b1, 1'b1, 0, "R1 stays clear");

    @(posedge clk); #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule